// File: doc/BRIEF.md
# Grouped Stride Prefetch Predictor

This block watches the stream of memory instructions leaving a load/store pipeline. Each access arrives as an instruction address (PC) and the effective address it touched. The block remembers recent memory instructions, learns the distance between consecutive addresses of each one, and proposes a prefetch address once that distance repeats.

The prediction table has 64 slots in 16 independent groups of 4. Each access searches only one group, chosen by a few low PC bits, so a lookup compares against four tags instead of sixty-four. Each slot keeps the low 16 PC bits as its tag. It also holds the last address, the learned stride and a confidence state.

Requests that would not help are dropped. These are strides no larger than half a cache line, and targets that fall in the line already being accessed. A surviving request is a line-aligned address, presented for one cycle.

Top module: `rpt_stride_prefetch`

## Requirements
- R1: While reset is held and after its release, `pfValid` is 0. Every PC misses on its first access after reset.
- R2: The group is taken from `accPc[5:2]`. The tag is `accPc[15:0]`, so two PCs that differ only in bits 31..16 share one slot.
- R3: A miss claims a slot and records the address with stride 0 in the initial state. A constant stride therefore yields its first prefetch on the third access of that PC.
- R4: On a hit, the new stride is the access address minus the stored address. A prefetch is `accAddr + stride` with its low 6 bits cleared (64-byte lines). `pfValid` is high in the cycle after the access and low after any cycle without an access.
- R5: A steady slot that sees a different stride drops to the initial state and keeps its old stride. The next access that repeats the old stride returns it to steady and issues a prefetch.
- R6: No prefetch is issued when the magnitude of the stride is 32 bytes or less.
- R7: No prefetch is issued when the aligned target equals the line of the current access.
- R8: A miss replaces the least recently used of the four slots in its group. Any hit or allocation makes that slot the most recent.
- R9: Confidence follows four states: initial, transient, steady and no-prediction. A mismatch moves initial to transient and transient to no-prediction. A match moves no-prediction to transient, and transient or initial to steady. Only a matching access that lands in steady issues a prefetch.
- R10: Negative strides are learned and prefetched in the same way as positive ones.
- R11: Activity in one group never changes the slots of another group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | A memory instruction is presented this cycle |
| accPc | input | 32 | Instruction address of the access |
| accAddr | input | 32 | Effective data address of the access |
| pfValid | output | 1 | Prefetch request valid (one cycle after the access) |
| pfAddr | output | 32 | Line-aligned prefetch address |

## Verification
The stimulus uses several address patterns. Large constant forward and backward strides show that the slot takes two accesses to build confidence. Strides of exactly half a line are used, along with strides just over half a line whose target stays inside the current line, to separate the magnitude filter from the same-line filter. An irregular sequence walks the slot through transient and no-prediction, and a jump inside a steady run shows that the old stride is kept. Five PCs sharing one group, a PC aliased above bit 15, and a later return to another group's slot expose replacement order, tag width and group isolation.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2,
    ST_NOPRED = 2'd3
  } rptState_e;

  // datapath -> control: result of the group search
  typedef struct packed {
    logic      hit;
    logic      strideMatch;
    logic      farEnough;
    rptState_e state;
  } lookup_t;

  // control -> datapath: what to do at the next edge
  typedef struct packed {
    logic      writeEntry;
    logic      alloc;
    logic      loadStride;
    logic      issue;
    rptState_e nextState;
  } strobe_t;

endpackage

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
(
  input  logic    accValid,
  input  lookup_t look,
  output strobe_t strb
);

  always_comb begin
    strb = '0;
    strb.nextState = ST_INIT;
    if (accValid) begin
      strb.writeEntry = 1'b1;
      if (!look.hit) begin
        strb.alloc     = 1'b1;
        strb.nextState = ST_INIT;
      end else begin
        unique case (look.state)
          ST_INIT: begin
            if (look.strideMatch) strb.nextState = ST_STEADY;
            else begin strb.nextState = ST_TRANS; strb.loadStride = 1'b1; end
          end
          ST_TRANS: begin
            if (look.strideMatch) strb.nextState = ST_STEADY;
            else begin strb.nextState = ST_NOPRED; strb.loadStride = 1'b1; end
          end
          ST_STEADY: begin
            // a single stray access does not overwrite a trusted stride
            if (look.strideMatch) strb.nextState = ST_STEADY;
            else strb.nextState = ST_INIT;
          end
          default: begin
            if (look.strideMatch) strb.nextState = ST_TRANS;
            else begin strb.nextState = ST_NOPRED; strb.loadStride = 1'b1; end
          end
        endcase
        strb.issue = look.strideMatch && (strb.nextState == ST_STEADY) && look.farEnough;
      end
    end
  end

endmodule

// File: rtl/rpt_datapath.sv
module rpt_datapath
  import rpt_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PCW        = 32,
  parameter int GROUPS     = 16,
  parameter int WAYS       = 4,
  parameter int TAGW       = 16,
  parameter int LINE_BYTES = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [PCW-1:0] accPc,
  input  logic [AW-1:0]  accAddr,
  input  strobe_t        strb,
  output lookup_t        look,
  output logic           pfValid,
  output logic [AW-1:0]  pfAddr
);

  localparam int GRP_W = $clog2(GROUPS);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [AW-1:0] LINE_MASK = AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] HALF_LINE = AW'(LINE_BYTES / 2);

  logic [TAGW-1:0]  tagMem    [GROUPS][WAYS];
  logic [AW-1:0]    prevMem   [GROUPS][WAYS];
  logic [AW-1:0]    strideMem [GROUPS][WAYS];
  rptState_e        stateMem  [GROUPS][WAYS];
  logic             validMem  [GROUPS][WAYS];
  logic [WAY_W-1:0] ageMem    [GROUPS][WAYS];

  logic [GRP_W-1:0] grp;
  logic [TAGW-1:0]  tag;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay, victimWay, selWay;
  logic [AW-1:0]    newStride, absStride, candAddr, alignedCand;
  logic             unusedPcHi;

  assign grp        = accPc[ALIGN_BITS +: GRP_W];
  assign tag        = accPc[TAGW-1:0];
  assign unusedPcHi = ^accPc[PCW-1:TAGW];

  always_comb begin
    hitWay    = '0;
    victimWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitVec[w] = validMem[grp][w] && (tagMem[grp][w] == tag);
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (ageMem[grp][w] == WAY_W'(WAYS - 1)) victimWay = WAY_W'(w);
    end
  end

  assign selWay      = (|hitVec) ? hitWay : victimWay;
  assign newStride   = accAddr - prevMem[grp][selWay];
  assign absStride   = newStride[AW-1] ? (~newStride + 1'b1) : newStride;
  assign candAddr    = accAddr + newStride;
  assign alignedCand = candAddr & ~LINE_MASK;

  assign look.hit         = |hitVec;
  assign look.strideMatch = (newStride == strideMem[grp][selWay]);
  assign look.state       = stateMem[grp][selWay];
  assign look.farEnough   = (absStride > HALF_LINE) &&
                            (alignedCand != (accAddr & ~LINE_MASK));

  // valid bits, recency and the output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < GROUPS; g++)
        for (int w = 0; w < WAYS; w++) begin
          validMem[g][w] <= 1'b0;
          ageMem[g][w]   <= WAY_W'(w);
        end
      pfValid <= 1'b0;
      pfAddr  <= '0;
    end else begin
      pfValid <= strb.issue;
      if (strb.issue) pfAddr <= alignedCand;
      if (strb.writeEntry) begin
        validMem[grp][selWay] <= 1'b1;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == selWay) ageMem[grp][w] <= '0;
          else if (ageMem[grp][w] < ageMem[grp][selWay])
            ageMem[grp][w] <= ageMem[grp][w] + 1'b1;
        end
      end
    end
  end

  // slot contents
  always_ff @(posedge clk) begin
    if (strb.writeEntry) begin
      prevMem[grp][selWay]  <= accAddr;
      stateMem[grp][selWay] <= strb.nextState;
      if (strb.alloc) begin
        tagMem[grp][selWay]    <= tag;
        strideMem[grp][selWay] <= '0;
      end else if (strb.loadStride) begin
        strideMem[grp][selWay] <= newStride;
      end
    end
  end

endmodule

// File: rtl/rpt_stride_prefetch.sv
module rpt_stride_prefetch
  import rpt_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PCW        = 32,
  parameter int GROUPS     = 16,
  parameter int WAYS       = 4,
  parameter int TAGW       = 16,
  parameter int LINE_BYTES = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           accValid,
  input  logic [PCW-1:0] accPc,
  input  logic [AW-1:0]  accAddr,
  output logic           pfValid,
  output logic [AW-1:0]  pfAddr
);

  lookup_t look;
  strobe_t strb;

  rpt_ctrl u_ctrl (
    .accValid (accValid),
    .look     (look),
    .strb     (strb)
  );

  rpt_datapath #(
    .AW(AW), .PCW(PCW), .GROUPS(GROUPS), .WAYS(WAYS),
    .TAGW(TAGW), .LINE_BYTES(LINE_BYTES), .ALIGN_BITS(ALIGN_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .accPc   (accPc),
    .accAddr (accAddr),
    .strb    (strb),
    .look    (look),
    .pfValid (pfValid),
    .pfAddr  (pfAddr)
  );

endmodule

// File: rtl/rpt_stride_prefetch_chk.sv
module rpt_stride_prefetch_chk #(
  parameter int AW         = 32,
  parameter int PCW        = 32,
  parameter int LINE_BYTES = 64
) (
  input logic           clk,
  input logic           rstN,
  input logic           accValid,
  input logic [PCW-1:0] accPc,
  input logic [AW-1:0]  accAddr,
  input logic           pfValid,
  input logic [AW-1:0]  pfAddr
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  assert_pf_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> (pfAddr[OFF_W-1:0] == '0));

  assert_pf_follows_access_R4: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> $past(accValid));

  assert_pf_new_line_R7: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> (pfAddr[AW-1:OFF_W] != $past(accAddr[AW-1:OFF_W])));

  // same instruction repeating the same address has stride 0
  assert_zero_stride_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && $past(accValid) && accPc == $past(accPc) && accAddr == $past(accAddr))
      |=> !pfValid);

endmodule

bind rpt_stride_prefetch rpt_stride_prefetch_chk #(
  .AW(AW), .PCW(PCW), .LINE_BYTES(LINE_BYTES)
) u_chk (.*);

// File: tb/rpt_stride_prefetch_tb.sv
module rpt_stride_prefetch_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        v;
    logic [31:0] a;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accPc = '0;
  logic [31:0] accAddr = '0;
  logic        pfValid;
  logic [31:0] pfAddr;
  logic        lastValid = 1'b0;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;

  rpt_stride_prefetch u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accPc(accPc),
    .accAddr(accAddr), .pfValid(pfValid), .pfAddr(pfAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) lastValid <= accValid;

  // monitor: compare one expected item per access, one cycle later
  always @(negedge clk) begin
    if (rstN && lastValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4: output seen with no expected item (pfValid=%0b pfAddr=%h)", pfValid, pfAddr);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (pfValid !== e.v || (e.v && pfAddr !== e.a)) begin
          errors++;
          $display("FAIL %s: got pfValid=%0b pfAddr=%h, expected pfValid=%0b pfAddr=%h",
                   e.req, pfValid, pfAddr, e.v, e.a);
        end
      end
    end else if (rstN && pfValid !== 1'b0) begin
      checks++;
      errors++;
      $display("FAIL R4: pfValid=%0b after idle cycle, expected 0", pfValid);
    end
  end

  task automatic access(input logic [31:0] pc, input logic [31:0] addr,
                        input logic v, input logic [31:0] a, input string req);
    exp_t e;
    @(negedge clk);
    accValid = 1'b1;
    accPc    = pc;
    accAddr  = addr;
    e.v = v; e.a = a; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      accValid = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout, expected finish");
    finish_run();
  end

  initial begin
    // R1: quiet during reset
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (pfValid !== 1'b0) begin
        errors++;
        $display("FAIL R1: pfValid=%0b during reset, expected 0", pfValid);
      end
    end
    rstN = 1'b1;
    idle(2);

    // R1 R3 R4: group 0, stride 0x100
    access(32'h0000_0100, 32'h0000_2000, 1'b0, 32'h0, "R1");
    access(32'h0000_0100, 32'h0000_2100, 1'b0, 32'h0, "R3");
    access(32'h0000_0100, 32'h0000_2200, 1'b1, 32'h0000_2300, "R3");
    access(32'h0000_0100, 32'h0000_2300, 1'b1, 32'h0000_2400, "R4");

    // R6: stride exactly half a line never prefetches
    access(32'h0000_0104, 32'h0000_3000, 1'b0, 32'h0, "R6");
    access(32'h0000_0104, 32'h0000_3020, 1'b0, 32'h0, "R6");
    access(32'h0000_0104, 32'h0000_3040, 1'b0, 32'h0, "R6");
    access(32'h0000_0104, 32'h0000_3060, 1'b0, 32'h0, "R6");

    // R7: stride 40, target inside current line suppressed
    access(32'h0000_0108, 32'h0000_1000, 1'b0, 32'h0, "R7");
    access(32'h0000_0108, 32'h0000_1028, 1'b0, 32'h0, "R7");
    access(32'h0000_0108, 32'h0000_1050, 1'b0, 32'h0, "R7");
    access(32'h0000_0108, 32'h0000_1078, 1'b1, 32'h0000_1080, "R7");

    // R10: negative stride
    access(32'h0000_010C, 32'h0000_8000, 1'b0, 32'h0, "R10");
    access(32'h0000_010C, 32'h0000_7F00, 1'b0, 32'h0, "R10");
    access(32'h0000_010C, 32'h0000_7E00, 1'b1, 32'h0000_7D00, "R10");

    // R5: steady slot survives one jump
    access(32'h0000_0100, 32'h0000_9000, 1'b0, 32'h0, "R5");
    access(32'h0000_0100, 32'h0000_9100, 1'b1, 32'h0000_9200, "R5");

    // R9: init -> trans -> nopred -> trans -> steady
    access(32'h0000_0110, 32'h0000_4000, 1'b0, 32'h0, "R9");
    access(32'h0000_0110, 32'h0000_4040, 1'b0, 32'h0, "R9");
    access(32'h0000_0110, 32'h0000_4100, 1'b0, 32'h0, "R9");
    access(32'h0000_0110, 32'h0000_41C0, 1'b0, 32'h0, "R9");
    access(32'h0000_0110, 32'h0000_4280, 1'b1, 32'h0000_4340, "R9");

    // R2: alias above bit 15 continues the 0x100 slot
    access(32'h0001_0100, 32'h0000_9200, 1'b1, 32'h0000_9300, "R2");

    idle(2);

    // R8: five PCs in group 5, LRU eviction of the second
    access(32'h0000_1014, 32'h0000_A000, 1'b0, 32'h0, "R8");
    access(32'h0000_1054, 32'h0000_5100, 1'b0, 32'h0, "R8");
    access(32'h0000_1094, 32'h0000_5200, 1'b0, 32'h0, "R8");
    access(32'h0000_10D4, 32'h0000_C000, 1'b0, 32'h0, "R8");
    access(32'h0000_1014, 32'h0000_A100, 1'b0, 32'h0, "R8");
    access(32'h0000_1114, 32'h0000_D000, 1'b0, 32'h0, "R8");
    access(32'h0000_1094, 32'h0000_5300, 1'b0, 32'h0, "R8");
    access(32'h0000_1094, 32'h0000_5400, 1'b1, 32'h0000_5500, "R8");
    access(32'h0000_1054, 32'h0000_5200, 1'b0, 32'h0, "R8");
    access(32'h0000_1054, 32'h0000_5300, 1'b0, 32'h0, "R8");
    access(32'h0000_1054, 32'h0000_5400, 1'b1, 32'h0000_5500, "R8");

    // R11: group 0 slot untouched by group 5 traffic
    access(32'h0000_0100, 32'h0000_9300, 1'b1, 32'h0000_9400, "R11");

    idle(4);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R4: %0d expected items left, expected 0", expQ.size());
    end
    finish_run();
  end

endmodule